// File: doc/BRIEF.md
# Banked Register File Address Decoder

This block sits between a small 8-bit processor core and its register file. Every data access the core makes carries a 7-bit operand address. The block turns that operand into a 9-bit effective address. When the operand is nonzero it uses two direct bank bits. When the operand is zero it takes the address from an 8-bit pointer register plus one high bank bit. It then routes the access to one of four places: general purpose RAM, the pointer register, an external port for special function registers, or nothing at all.

The low 32 locations of each bank hold special function registers. The pointer is kept inside this block and can be reached at offset 04h in every bank. The other special function slots are passed to the external port, which returns its read data in the same cycle. General purpose RAM is 128 bytes. The top 16 bytes of bank 1 are a second window onto the top 16 bytes of bank 0. Locations with no storage read as zero and ignore writes.

Reads are registered: the selected value appears on the read data output one cycle after the read strobe, and the output is zero after any cycle with no read.

Top module: `bank_regfile_dec`

## Requirements
- R1: The effective address is {bank_sel, op_addr} when op_addr is nonzero. When op_addr is 00h it is {ptr_hi, pointer}, so an indirect access and a direct access that reach the same 9-bit address see the same storage.
- R2: General purpose RAM answers at bank 0 offsets 20h-7Fh (96 bytes) and at bank 1 offsets 20h-3Fh (32 bytes). All of these are separate storage.
- R3: Bank 1 offsets 70h-7Fh (effective addresses F0h-FFh) reach the same bytes as bank 0 offsets 70h-7Fh.
- R4: The following locations have no storage: bank 1 offsets 40h-6Fh, and banks 2 and 3 at offsets 20h-7Fh. They read 0, and writes to them change no storage.
- R5: The pointer register answers at offset 04h of every bank for both reads and writes. Without a write to it, it holds its value.
- R6: Offsets 01h-1Fh other than 04h go to the external port. The port read strobe follows rd_en and the port write strobe follows wr_en. sfr_addr carries the 9-bit effective address and sfr_wdata carries wr_data. A read returns sfr_rdata.
- R7: An indirect access whose effective offset is 00h (the alias location itself) reads 0, changes no state and raises no port strobe.
- R8: rd_data shows, one clock after rd_en, the value the location held before that clock's write. After a clock with rd_en low it shows 0.
- R9: After reset the pointer, all general purpose RAM and rd_data are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_addr | input | 7 | Instruction operand address; 00h selects indirect access |
| bank_sel | input | 2 | Bank bits for direct access |
| ptr_hi | input | 1 | High bank bit for indirect access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| sfr_addr | output | 9 | Effective address passed to the special function register port |
| sfr_rd | output | 1 | Port read strobe |
| sfr_wr | output | 1 | Port write strobe |
| sfr_wdata | output | 8 | Port write data |
| sfr_rdata | input | 8 | Port read data, valid in the strobe cycle |

## Verification
The assertions check several rules on every cycle. Port strobes only ever carry an offset inside the special function window. The pointer holds its value without a write. rd_data falls to zero after an idle cycle. A read through the alias location with a zero pointer offset returns zero.

Some behaviour can only be shown by the bench's scenarios, because it depends on the contents of storage over time. These are: the mirror between the two banks' top windows, that holes keep no data and do not alias into RAM, and that direct and indirect access reach the same byte. The bench compares every access against its own address model under seeded random traffic.

// File: rtl/bank_regfile_dec_pkg.sv
package bank_regfile_dec_pkg;
    localparam int OP_W      = 7;
    localparam int DW        = 8;
    localparam int EA_W      = OP_W + 2;
    localparam int GPR_DEPTH = 128;
    localparam int IDX_W     = $clog2(GPR_DEPTH);

    localparam logic [OP_W-1:0] SFR_SPAN    = 7'h20;
    localparam logic [OP_W-1:0] PTR_OFS     = 7'h04;
    localparam logic [OP_W-1:0] B1_RAM_END  = 7'h40;
    localparam logic [OP_W-1:0] MIRROR_BASE = 7'h70;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_PTR  = 2'd1,
        TGT_SFR  = 2'd2,
        TGT_GPR  = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [IDX_W-1:0] idx;
        logic [EA_W-1:0]  ea;
    } route_t;
endpackage

// File: rtl/bank_addr_route.sv
module bank_addr_route
    import bank_regfile_dec_pkg::*;
#(
    parameter bit MIRROR_EN = 1'b1
) (
    input  logic [OP_W-1:0] op_addr,
    input  logic [1:0]      bank_sel,
    input  logic            ptr_hi,
    input  logic [OP_W:0]   ptr_q,
    output route_t          route
);
    localparam logic [OP_W-1:0] B0_BASE = SFR_SPAN;
    localparam logic [OP_W-1:0] B1_OFFS = 7'h40;

    logic            indirect;
    logic [EA_W-1:0] ea;
    logic [OP_W-1:0] lo;
    logic [1:0]      bk;
    logic            mirror_hit;

    assign indirect = (op_addr == '0);
    assign ea       = indirect ? {ptr_hi, ptr_q} : {bank_sel, op_addr};
    assign lo       = ea[OP_W-1:0];
    assign bk       = ea[EA_W-1:EA_W-2];

    generate
        if (MIRROR_EN) begin : g_mirror
            assign mirror_hit = (bk == 2'd1) && (lo >= MIRROR_BASE);
        end else begin : g_no_mirror
            assign mirror_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        route.ea  = ea;
        route.tgt = TGT_NONE;
        route.idx = '0;
        if (lo == '0) begin
            route.tgt = TGT_NONE;
        end else if (lo == PTR_OFS) begin
            route.tgt = TGT_PTR;
        end else if (lo < SFR_SPAN) begin
            route.tgt = TGT_SFR;
        end else if (bk == 2'd0 || mirror_hit) begin
            route.tgt = TGT_GPR;
            route.idx = lo - B0_BASE;
        end else if (bk == 2'd1 && lo < B1_RAM_END) begin
            route.tgt = TGT_GPR;
            route.idx = lo + B1_OFFS;
        end
    end
endmodule

// File: rtl/gpr_store.sv
module gpr_store
    import bank_regfile_dec_pkg::*;
#(
    parameter int DEPTH = GPR_DEPTH,
    parameter int W     = DW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [W-1:0]             wdata,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[idx];

    // R2: a write lands on the addressed byte by the next cycle
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/bank_regfile_dec.sv
module bank_regfile_dec
    import bank_regfile_dec_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [6:0]      op_addr,
    input  logic [1:0]      bank_sel,
    input  logic            ptr_hi,
    input  logic            rd_en,
    input  logic            wr_en,
    input  logic [7:0]      wr_data,
    output logic [7:0]      rd_data,
    output logic [8:0]      sfr_addr,
    output logic            sfr_rd,
    output logic            sfr_wr,
    output logic [7:0]      sfr_wdata,
    input  logic [7:0]      sfr_rdata
);
    typedef struct packed {
        logic [OP_W:0] ptr;
        logic [DW-1:0] rdat;
    } state_t;

    state_t        st_d, st_q;
    route_t        route;
    logic [DW-1:0] mem_rdata;
    logic          mem_we;

    bank_addr_route #(.MIRROR_EN(1'b1)) u_route (
        .op_addr  (op_addr),
        .bank_sel (bank_sel),
        .ptr_hi   (ptr_hi),
        .ptr_q    (st_q.ptr),
        .route    (route)
    );

    assign mem_we = wr_en && (route.tgt == TGT_GPR);

    gpr_store #(.DEPTH(GPR_DEPTH), .W(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .idx   (route.idx),
        .wdata (wr_data),
        .rdata (mem_rdata)
    );

    assign sfr_addr  = route.ea;
    assign sfr_rd    = rd_en && (route.tgt == TGT_SFR);
    assign sfr_wr    = wr_en && (route.tgt == TGT_SFR);
    assign sfr_wdata = wr_data;

    always_comb begin
        st_d      = st_q;
        st_d.rdat = '0;
        if (rd_en) begin
            unique case (route.tgt)
                TGT_GPR:  st_d.rdat = mem_rdata;
                TGT_PTR:  st_d.rdat = st_q.ptr;
                TGT_SFR:  st_d.rdat = sfr_rdata;
                default:  st_d.rdat = '0;
            endcase
        end
        if (wr_en && route.tgt == TGT_PTR) begin
            st_d.ptr = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdat;

    // R6: port strobes only carry special function offsets
    assert_sfr_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd || sfr_wr) |-> (sfr_addr[6:0] != 7'h00 && sfr_addr[6:0] != 7'h04
                                && sfr_addr[6:0] < 7'h20));

    // R5: pointer holds without a write strobe
    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.ptr));

    // R8: idle cycle gives zero read data
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == 8'h00));

    // R7: alias read through a zero pointer offset returns zero
    assert_alias_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && op_addr == 7'h00 && st_q.ptr[6:0] == 7'h00) |=> (rd_data == 8'h00));
endmodule

// File: tb/sim_bank_regfile_dec.sv
module sim_bank_regfile_dec;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] op_addr = '0;
    logic [1:0] bank_sel = '0;
    logic       ptr_hi = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [8:0] sfr_addr;
    logic       sfr_rd, sfr_wr;
    logic [7:0] sfr_wdata;
    logic [7:0] sfr_rdata;

    int checks = 0;
    int failures = 0;

    logic [7:0] mem_m [128];
    logic [7:0] ptr_m;
    logic [7:0] exp_rd;
    string      exp_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] sfr_val(input logic [8:0] a);
        return a[7:0] ^ {7'b0, a[8]} ^ 8'hA5;
    endfunction

    assign sfr_rdata = sfr_val(sfr_addr);

    bank_regfile_dec u0 (
        .clk(clk), .rst_n(rst_n), .op_addr(op_addr), .bank_sel(bank_sel),
        .ptr_hi(ptr_hi), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    // kinds: 0 none, 1 pointer, 2 port, 3 ram
    function automatic logic [8:0] m_ea(input logic [6:0] op, input logic [1:0] bk,
                                       input logic hi, input logic [7:0] p);
        return (op == 7'h00) ? {hi, p} : {bk, op};
    endfunction

    function automatic int m_kind(input logic [8:0] a);
        logic [6:0] lo = a[6:0];
        if (lo == 7'h00) return 0;
        if (lo == 7'h04) return 1;
        if (lo < 7'h20)  return 2;
        if (a[8:7] == 2'd0) return 3;
        if (a[8:7] == 2'd1 && (lo < 7'h40 || lo >= 7'h70)) return 3;
        return 0;
    endfunction

    function automatic int m_idx(input logic [8:0] a);
        int lo = int'(a[6:0]);
        if (a[8:7] == 2'd1 && lo < 'h40) return lo - 'h20 + 96;
        return lo - 'h20;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic acc(input logic rd, input logic wr, input logic [1:0] bk,
                       input logic hi, input logic [6:0] op, input logic [7:0] wd,
                       input string tag);
        logic [8:0] a;
        int         k;
        string      t;
        @(negedge clk);
        chk(exp_tag, rd_data, exp_rd, "rd_data");
        rd_en = rd; wr_en = wr; bank_sel = bk; ptr_hi = hi; op_addr = op; wr_data = wd;
        #1;
        a = m_ea(op, bk, hi, ptr_m);
        k = m_kind(a);
        chk("R6", {sfr_rd, sfr_wr}, {rd && k == 2, wr && k == 2}, "port strobes");
        if (k == 2) begin
            chk("R6", sfr_addr, a, "sfr_addr");
            if (wr) chk("R6", sfr_wdata, wd, "sfr_wdata");
        end
        if (!rd) exp_rd = 8'h00;
        else case (k)
            1: exp_rd = ptr_m;
            2: exp_rd = sfr_val(a);
            3: exp_rd = mem_m[m_idx(a)];
            default: exp_rd = 8'h00;
        endcase
        if (tag != "") t = tag;
        else if (!rd) t = "R8";
        else if (k == 1) t = "R5";
        else if (k == 2) t = "R6";
        else if (k == 3) t = (op == 7'h00) ? "R1" : "R2";
        else t = (op == 7'h00) ? "R7" : "R4";
        exp_tag = t;
        @(posedge clk);
        if (wr && k == 1) ptr_m = wd;
        if (wr && k == 3) mem_m[m_idx(a)] = wd;
    endtask

    task automatic rd_dir(input logic [1:0] bk, input logic [6:0] op, input string tag);
        acc(1'b1, 1'b0, bk, 1'b0, op, 8'h00, tag);
    endtask

    task automatic wr_dir(input logic [1:0] bk, input logic [6:0] op, input logic [7:0] d);
        acc(1'b0, 1'b1, bk, 1'b0, op, d, "");
    endtask

    initial begin
        repeat (2000 * 100) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < 128; i++) mem_m[i] = 8'h00;
        ptr_m = 8'h00;
        exp_rd = 8'h00;
        exp_tag = "R9";
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1 chk("R9", rd_data, 8'h00, "rd_data after reset");
        @(negedge clk) rst_n = 1'b1;

        // R9: reset contents
        rd_dir(2'd0, 7'h04, "R9");
        rd_dir(2'd1, 7'h3F, "R9");
        rd_dir(2'd0, 7'h7F, "R9");

        // R3: mirror both directions
        wr_dir(2'd0, 7'h75, 8'h3C);
        rd_dir(2'd1, 7'h75, "R3");
        wr_dir(2'd1, 7'h7A, 8'h99);
        rd_dir(2'd0, 7'h7A, "R3");

        // R2: separate bank storage
        wr_dir(2'd1, 7'h25, 8'h11);
        wr_dir(2'd0, 7'h25, 8'h22);
        rd_dir(2'd1, 7'h25, "R2");
        rd_dir(2'd0, 7'h25, "R2");

        // R4: holes read zero and do not alias
        wr_dir(2'd0, 7'h50, 8'h5A);
        wr_dir(2'd1, 7'h50, 8'hFF);
        rd_dir(2'd1, 7'h50, "R4");
        wr_dir(2'd2, 7'h30, 8'hEE);
        rd_dir(2'd2, 7'h30, "R4");
        rd_dir(2'd3, 7'h7F, "R4");
        rd_dir(2'd0, 7'h50, "R4");

        // R5 / R1: pointer in every bank, indirect equals direct
        wr_dir(2'd3, 7'h04, 8'h25);
        rd_dir(2'd0, 7'h04, "R5");
        rd_dir(2'd2, 7'h04, "R5");
        acc(1'b1, 1'b0, 2'd3, 1'b0, 7'h00, 8'h00, "R1");
        wr_dir(2'd1, 7'h04, 8'hA5);
        acc(1'b1, 1'b0, 2'd0, 1'b0, 7'h00, 8'h00, "R1");
        acc(1'b0, 1'b1, 2'd0, 1'b0, 7'h00, 8'h77, "R1");
        rd_dir(2'd1, 7'h25, "R1");
        acc(1'b1, 1'b0, 2'd0, 1'b1, 7'h00, 8'h00, "R1");

        // R7: alias location through a zero pointer
        wr_dir(2'd0, 7'h04, 8'h00);
        acc(1'b1, 1'b0, 2'd0, 1'b0, 7'h00, 8'h00, "R7");
        acc(1'b0, 1'b1, 2'd0, 1'b0, 7'h00, 8'h55, "R7");
        rd_dir(2'd0, 7'h04, "R7");
        wr_dir(2'd0, 7'h04, 8'h80);
        acc(1'b1, 1'b1, 2'd0, 1'b1, 7'h00, 8'h66, "R7");
        rd_dir(2'd2, 7'h04, "R7");

        // R6: port reads and writes
        rd_dir(2'd2, 7'h0B, "R6");
        acc(1'b0, 1'b1, 2'd1, 1'b0, 7'h1F, 8'hC3, "R6");

        // R8: read-before-write and idle zero
        wr_dir(2'd0, 7'h40, 8'h12);
        acc(1'b1, 1'b1, 2'd0, 1'b0, 7'h40, 8'h34, "R8");
        rd_dir(2'd0, 7'h40, "R8");
        acc(1'b0, 1'b0, 2'd0, 1'b0, 7'h40, 8'h00, "R8");

        // seeded random traffic, op 00h and 04h weighted up
        for (int n = 0; n < 3000; n++) begin
            logic [6:0] op;
            r = $urandom;
            case (r[3:0])
                4'd0, 4'd1: op = 7'h00;
                4'd2:       op = 7'h04;
                4'd3:       op = {3'b111, r[11:8]};
                default:    op = r[14:8];
            endcase
            acc(r[16], r[17] & ~(r[18] & r[19]), r[21:20], r[22], op, r[31:24], "");
        end
        acc(1'b0, 1'b0, 2'd0, 1'b0, 7'h20, 8'h00, "");
        @(negedge clk);
        chk(exp_tag, rd_data, exp_rd, "rd_data final");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule